// File: doc/BRIEF.md
# Half-Rate Pipe Issue Dispatcher

This block decides, every clock, which of four sub-partition issuers may send their oldest pending instruction into an execution pipe. Each issuer offers the head of its own in-order queue, tagged with a 3-bit pipe class. Four classes are private to each issuer: integer ALU, FP32 fused multiply-add, paired half-precision and the transcendental/conversion unit. The other four classes are load/store, texture, address divergence and convergence barrier. One copy of each of those is shared by the whole cluster.

The ALU, FMA and FP16 pipes of an issuer take a new instruction at most every other cycle. An issuer can still dispatch every cycle when its instruction stream moves between different half-rate pipes. Each shared pipe takes one instruction per cycle from the cluster, picked by a round-robin arbiter that is private to that pipe. An issuer that cannot dispatch raises its stall line and leaves its head in place. Nothing is reordered.

Each half-rate pipe has a gate machine with two states. In GATE_READY the pipe accepts work. The LAUNCH transition (a dispatch to that pipe) moves it to GATE_RECOVER. The RELEASE transition returns it to GATE_READY on the next clock without condition. The HOLD transition keeps GATE_READY when nothing is dispatched. Each shared pipe's arbiter keeps a priority pointer. After a grant, the pointer ADVANCEs to the slot after the winner. It keeps its value in cycles with no request.

Top module: `issue_dispatch_cluster`

## Requirements
- R1: Each issuer dispatches at most one instruction per cycle. `issue_go[i]` is never high without `head_valid[i]`, and `stall[i]` equals `head_valid[i]` and not `issue_go[i]`.
- R2: Class codes are: 0 ALU, 1 FMA, 2 FP16, 3 XU (local); 4 LSU, 5 TEX, 6 ADU, 7 CBU (shared). A dispatch of a local class raises `local_valid[4*i+code]` in the same cycle and no other local bit of that issuer.
- R3: After an issuer dispatches to its ALU, FMA or FP16 pipe, the same pipe of that issuer accepts nothing in the next cycle, and a head targeting it stalls.
- R4: A stream that alternates between two different half-rate pipes (ALU, FMA, ALU, FMA) dispatches in every cycle.
- R5: FP16 and FMA are separate: FP16 right after FMA dispatches, and FP16 right after FP16 stalls.
- R6: The XU pipe accepts an instruction from its issuer in every cycle.
- R7: Each shared pipe `p` (class 4+p) receives at most one instruction per cycle. `shared_valid[p]` marks it, and `shared_src[2p+1:2p]` holds the winning issuer's index.
- R8: Shared arbitration is round-robin. The winner is the first requester at or after the pointer, in increasing index order with wrap. After a grant the pointer moves to winner+1. If any issuer requests pipe p, one of them is granted.
- R9: A stalled issuer dispatches nothing else that cycle, and its held head is the next instruction it dispatches, so per-issuer program order holds.
- R10: After reset every half-rate pipe is ready and every arbiter pointer is at issuer 0.
- R11: Different shared pipes, and the local pipes of different issuers, do not block one another in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 4 | Issuer i has a queue head on offer |
| head_pipe | input | 12 | Class of issuer i head at bits [3i+2:3i] |
| issue_go | output | 4 | Issuer i dispatches its head this cycle (queue pop) |
| stall | output | 4 | Issuer i holds a head that could not dispatch |
| local_valid | output | 16 | Local pipe strobe, bit 4i+code |
| shared_valid | output | 4 | Shared pipe p receives an instruction |
| shared_src | output | 8 | Issuer index feeding shared pipe p, bits [2p+1:2p] |

## Verification
The assertions assume that each issuer's queue keeps its head class steady until `issue_go` pops it. They also assume that `head_valid` is low during reset, so no gate is launched before the first checked cycle. The directed tasks drive heads just after a rising edge and hold them for the whole cycle. After a stall they drive the same head again, and they pop their model queues only on an observed `issue_go`. The program-order stream follows the same rule: it advances each issuer's index only on a dispatch.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

    typedef enum logic [2:0] {
        PC_ALU  = 3'd0,
        PC_FMA  = 3'd1,
        PC_FP16 = 3'd2,
        PC_XU   = 3'd3,
        PC_LSU  = 3'd4,
        PC_TEX  = 3'd5,
        PC_ADU  = 3'd6,
        PC_CBU  = 3'd7
    } pipe_cls_e;

    typedef enum logic {
        GATE_READY   = 1'b0,
        GATE_RECOVER = 1'b1
    } gate_state_e;

    localparam int CLS_W        = 3;
    localparam int LOCAL_PIPES  = 4;
    localparam int SHARED_PIPES = 4;
    localparam int HALF_RATE_N  = 3;  // classes below this code are half-rate

endpackage

// File: rtl/pipe_rate_gate.sv
module pipe_rate_gate
    import dispatch_pkg::*;
#(
    parameter bit HALF_RATE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic ready
);

    gate_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_READY;
        else        state_q <= state_d;
    end

    // transitions: LAUNCH, HOLD, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_READY:   state_d = (launch && HALF_RATE) ? GATE_RECOVER : GATE_READY;
            GATE_RECOVER: state_d = GATE_READY;
            default:      state_d = GATE_READY;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            GATE_READY:   ready = 1'b1;
            GATE_RECOVER: ready = 1'b0;
            default:      ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/shared_rr_arbiter.sv
module shared_rr_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any_grant,
    output logic [IW-1:0] winner
);

    logic [IW-1:0] ptr_q, ptr_d;

    always_comb begin
        int idx;
        logic found;
        grant  = '0;
        winner = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                winner     = IW'(idx);
            end
        end
        any_grant = found;
    end

    // ADVANCE past the winner; keep pointer when idle
    always_comb begin
        ptr_d = ptr_q;
        if (any_grant) begin
            if (winner == IW'(N - 1)) ptr_d = '0;
            else                      ptr_d = winner + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/subpart_issue_ctrl.sv
module subpart_issue_ctrl
    import dispatch_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    head_valid,
    input  logic [CLS_W-1:0]        head_pipe,
    input  logic [SHARED_PIPES-1:0] shared_grant,
    output logic [SHARED_PIPES-1:0] shared_req,
    output logic                    issue_go,
    output logic                    stall,
    output logic [LOCAL_PIPES-1:0]  local_valid
);

    pipe_cls_e              cls;
    logic                   is_local;
    logic [1:0]             sub_idx;
    logic [LOCAL_PIPES-1:0] gate_ready;
    logic                   can_go;

    assign cls     = pipe_cls_e'(head_pipe);
    assign sub_idx = head_pipe[1:0];

    always_comb begin
        unique case (cls)
            PC_ALU, PC_FMA, PC_FP16, PC_XU: is_local = 1'b1;
            default:                        is_local = 1'b0;
        endcase
    end

    // one rate gate per local pipe; only the first classes are half-rate
    for (genvar g = 0; g < LOCAL_PIPES; g++) begin : g_gate
        pipe_rate_gate #(
            .HALF_RATE(g < HALF_RATE_N)
        ) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .launch(local_valid[g]),
            .ready (gate_ready[g])
        );
    end

    always_comb begin
        shared_req = '0;
        if (head_valid && !is_local) shared_req[sub_idx] = 1'b1;
    end

    assign can_go   = is_local ? gate_ready[sub_idx] : shared_grant[sub_idx];
    assign issue_go = head_valid && can_go;
    assign stall    = head_valid && !can_go;

    always_comb begin
        local_valid = '0;
        if (issue_go && is_local) local_valid[sub_idx] = 1'b1;
    end

endmodule

// File: rtl/issue_dispatch_cluster.sv
module issue_dispatch_cluster
    import dispatch_pkg::*;
#(
    parameter int NSP = 4,
    localparam int SRC_W = (NSP > 1) ? $clog2(NSP) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSP-1:0]                head_valid,
    input  logic [NSP*CLS_W-1:0]          head_pipe,
    output logic [NSP-1:0]                issue_go,
    output logic [NSP-1:0]                stall,
    output logic [NSP*LOCAL_PIPES-1:0]    local_valid,
    output logic [SHARED_PIPES-1:0]       shared_valid,
    output logic [SHARED_PIPES*SRC_W-1:0] shared_src
);

    logic [SHARED_PIPES-1:0] sp_req   [NSP];
    logic [SHARED_PIPES-1:0] sp_grant [NSP];
    logic [NSP-1:0]          pipe_req   [SHARED_PIPES];
    logic [NSP-1:0]          pipe_grant [SHARED_PIPES];

    for (genvar i = 0; i < NSP; i++) begin : g_sp
        subpart_issue_ctrl u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .head_valid  (head_valid[i]),
            .head_pipe   (head_pipe[i*CLS_W +: CLS_W]),
            .shared_grant(sp_grant[i]),
            .shared_req  (sp_req[i]),
            .issue_go    (issue_go[i]),
            .stall       (stall[i]),
            .local_valid (local_valid[i*LOCAL_PIPES +: LOCAL_PIPES])
        );
        for (genvar p = 0; p < SHARED_PIPES; p++) begin : g_xpose
            assign pipe_req[p][i] = sp_req[i][p];
            assign sp_grant[i][p] = pipe_grant[p][i];
        end
    end

    for (genvar p = 0; p < SHARED_PIPES; p++) begin : g_shared
        shared_rr_arbiter #(
            .N(NSP)
        ) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (pipe_req[p]),
            .grant    (pipe_grant[p]),
            .any_grant(shared_valid[p]),
            .winner   (shared_src[p*SRC_W +: SRC_W])
        );
    end

endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker
    import dispatch_pkg::*;
#(
    parameter int NSP = 4,
    localparam int SRC_W = (NSP > 1) ? $clog2(NSP) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NSP-1:0]                head_valid,
    input logic [NSP*CLS_W-1:0]          head_pipe,
    input logic [NSP-1:0]                issue_go,
    input logic [NSP-1:0]                stall,
    input logic [NSP*LOCAL_PIPES-1:0]    local_valid,
    input logic [SHARED_PIPES-1:0]       shared_valid,
    input logic [SHARED_PIPES*SRC_W-1:0] shared_src
);

    logic [NSP-1:0] hit  [SHARED_PIPES];
    logic [NSP-1:0] want [SHARED_PIPES];

    always_comb begin
        for (int p = 0; p < SHARED_PIPES; p++) begin
            for (int i = 0; i < NSP; i++) begin
                want[p][i] = head_valid[i] &&
                             (head_pipe[i*CLS_W +: CLS_W] == CLS_W'(LOCAL_PIPES + p));
                hit[p][i]  = issue_go[i] && want[p][i];
            end
        end
    end

    assert_go_needs_head_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_go & ~head_valid) == '0);

    assert_stall_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stall & issue_go) == '0);

    for (genvar i = 0; i < NSP; i++) begin : g_sp
        for (genvar g = 0; g < LOCAL_PIPES; g++) begin : g_pipe
            // strobe matches the dispatching head's class
            assert_local_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
                local_valid[i*LOCAL_PIPES + g] ==
                (issue_go[i] && head_pipe[i*CLS_W +: CLS_W] == CLS_W'(g)));
            if (g < HALF_RATE_N) begin : g_half
                assert_half_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    local_valid[i*LOCAL_PIPES + g] |=> !local_valid[i*LOCAL_PIPES + g]);
                assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (head_valid[i] && head_pipe[i*CLS_W +: CLS_W] == CLS_W'(g) &&
                     !$past(local_valid[i*LOCAL_PIPES + g])) |-> issue_go[i]);
            end else begin : g_full
                assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (head_valid[i] && head_pipe[i*CLS_W +: CLS_W] == CLS_W'(g)) |-> issue_go[i]);
            end
        end
    end

    for (genvar p = 0; p < SHARED_PIPES; p++) begin : g_sh
        assert_shared_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hit[p] == (shared_valid[p] ? (NSP'(1) << shared_src[p*SRC_W +: SRC_W]) : '0));
        assert_work_conserving_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (want[p] != '0) |-> shared_valid[p]);
    end

endmodule

bind issue_dispatch_cluster dispatch_checker #(.NSP(NSP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_valid  (head_valid),
    .head_pipe   (head_pipe),
    .issue_go    (issue_go),
    .stall       (stall),
    .local_valid (local_valid),
    .shared_valid(shared_valid),
    .shared_src  (shared_src)
);

// File: tb/issue_dispatch_cluster_bench.sv
`timescale 1ns/1ps
module issue_dispatch_cluster_bench;

    localparam logic [2:0] ALU = 3'd0, FMA = 3'd1, F16 = 3'd2, XU = 3'd3;
    localparam logic [2:0] LSU = 3'd4, TEX = 3'd5, ADU = 3'd6, CBU = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  head_valid;
    logic [11:0] head_pipe;
    logic [3:0]  issue_go;
    logic [3:0]  stall;
    logic [15:0] local_valid;
    logic [3:0]  shared_valid;
    logic [7:0]  shared_src;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    issue_dispatch_cluster u_issue_dispatch_cluster (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_pipe(head_pipe),
        .issue_go(issue_go), .stall(stall), .local_valid(local_valid),
        .shared_valid(shared_valid), .shared_src(shared_src)
    );

    function automatic logic [11:0] pk(input logic [2:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    task automatic chk(input logic [31:0] act, exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // drive one cycle of heads, then compare every output at the falling edge
    task automatic cyc(input logic [3:0] hv, input logic [11:0] hp,
                       input logic [3:0] e_go, input logic [3:0] e_sv,
                       input logic [7:0] e_src, input string tag);
        logic [15:0] e_lv;
        logic [7:0]  mask;
        @(posedge clk); #1;
        head_valid = hv;
        head_pipe  = hp;
        @(negedge clk);
        e_lv = '0;
        mask = '0;
        for (int i = 0; i < 4; i++)
            if (e_go[i] && hp[3*i+2] == 1'b0) e_lv[4*i + hp[3*i +: 2]] = 1'b1;
        for (int p = 0; p < 4; p++)
            if (e_sv[p]) mask[2*p +: 2] = 2'b11;
        chk(32'(issue_go), 32'(e_go), {tag, " issue_go"});
        chk(32'(stall), 32'(hv & ~e_go), {tag, " stall R1"});
        chk(32'(local_valid), 32'(e_lv), {tag, " local_valid R2"});
        chk(32'(shared_valid), 32'(e_sv), {tag, " shared_valid"});
        chk(32'(shared_src & mask), 32'(e_src & mask), {tag, " shared_src"});
    endtask

    task automatic idle();
        cyc(4'h0, pk(ALU, LSU, FMA, TEX), 4'h0, 4'h0, 8'h0, "R1 invalid heads ignored");
    endtask

    task automatic t_alternate();
        idle();
        cyc(4'h1, pk(ALU, 0, 0, 0), 4'h1, 0, 0, "R4 R10 first ALU");
        cyc(4'h1, pk(FMA, 0, 0, 0), 4'h1, 0, 0, "R4 FMA");
        cyc(4'h1, pk(ALU, 0, 0, 0), 4'h1, 0, 0, "R4 ALU");
        cyc(4'h1, pk(FMA, 0, 0, 0), 4'h1, 0, 0, "R4 FMA");
    endtask

    task automatic t_half_rate();
        idle();
        cyc(4'h1, pk(ALU, 0, 0, 0), 4'h1, 0, 0, "R3 ALU issue");
        cyc(4'h3, pk(ALU, ALU, 0, 0), 4'h2, 0, 0, "R3 R11 ALU busy, other issuer free");
        cyc(4'h1, pk(ALU, 0, 0, 0), 4'h1, 0, 0, "R9 held ALU goes");
    endtask

    task automatic t_fp16();
        idle();
        cyc(4'h4, pk(0, 0, FMA, 0), 4'h4, 0, 0, "R5 FMA");
        cyc(4'h4, pk(0, 0, F16, 0), 4'h4, 0, 0, "R5 FP16 after FMA");
        cyc(4'h4, pk(0, 0, F16, 0), 4'h0, 0, 0, "R5 FP16 after FP16 stalls");
        cyc(4'h4, pk(0, 0, F16, 0), 4'h4, 0, 0, "R5 FP16 retry");
    endtask

    task automatic t_xu();
        idle();
        for (int k = 0; k < 3; k++)
            cyc(4'h8, pk(0, 0, 0, XU), 4'h8, 0, 0, "R6 XU every cycle");
    endtask

    task automatic t_rr_rotate();
        idle();
        cyc(4'hF, pk(LSU, LSU, LSU, LSU), 4'h1, 4'h1, 8'h00, "R8 R10 ptr0 -> issuer0");
        cyc(4'hF, pk(LSU, LSU, LSU, LSU), 4'h2, 4'h1, 8'h01, "R8 R9 -> issuer1");
        cyc(4'hF, pk(LSU, LSU, LSU, LSU), 4'h4, 4'h1, 8'h02, "R8 -> issuer2");
        cyc(4'hF, pk(LSU, LSU, LSU, LSU), 4'h8, 4'h1, 8'h03, "R8 -> issuer3");
        cyc(4'hF, pk(LSU, LSU, LSU, LSU), 4'h1, 4'h1, 8'h00, "R7 R8 wrap -> issuer0");
    endtask

    task automatic t_rr_skip();
        idle();
        cyc(4'hC, pk(0, 0, TEX, TEX), 4'h4, 4'h2, 8'h08, "R8 skip to issuer2");
        cyc(4'h5, pk(TEX, 0, TEX, 0), 4'h1, 4'h2, 8'h00, "R8 wrap past 3 to issuer0");
    endtask

    task automatic t_parallel();
        idle();
        cyc(4'hF, pk(LSU, TEX, ADU, CBU), 4'hF, 4'hF, 8'b11_10_01_00, "R11 R7 all shared pipes");
    endtask

    task automatic t_mixed();
        idle();
        cyc(4'hF, pk(ALU, LSU, LSU, FMA), 4'hB, 4'h1, 8'h01, "R8 R11 mixed c1");
        cyc(4'hF, pk(ALU, XU, LSU, F16), 4'hE, 4'h1, 8'h02, "R3 R9 mixed c2");
    endtask

    task automatic t_stream();
        int qi[4];
        int total;
        logic [15:0] prev_lv;
        logic [2:0]  c;
        int cnt;
        logic ok;
        idle();
        qi = '{0, 0, 0, 0};
        total = 0;
        prev_lv = '0;
        for (int cyc_n = 0; cyc_n < 400; cyc_n++) begin
            @(posedge clk); #1;
            head_valid = 4'hF;
            for (int i = 0; i < 4; i++)
                head_pipe[3*i +: 3] = 3'((i * 5 + qi[i] * 3 + qi[i] / 3) % 8);
            @(negedge clk);
            chk(32'(local_valid & prev_lv & 16'h7777), 32'h0, "R3 stream half-rate spacing");
            for (int p = 0; p < 4; p++) begin
                cnt = 0;
                for (int i = 0; i < 4; i++)
                    if (issue_go[i] && head_pipe[3*i +: 3] == 3'(4 + p)) cnt++;
                chk(32'(cnt), 32'(shared_valid[p]), "R7 stream one per shared pipe");
            end
            for (int i = 0; i < 4; i++) begin
                if (issue_go[i]) begin
                    c = 3'((i * 5 + qi[i] * 3 + qi[i] / 3) % 8);
                    if (c < 3'd4) ok = local_valid[4*i + int'(c)];
                    else          ok = shared_valid[int'(c) - 4] &&
                                       shared_src[2*(int'(c) - 4) +: 2] == 2'(i);
                    chk(32'(ok), 32'h1, "R9 stream program order");
                    qi[i]++;
                    total++;
                end
            end
            prev_lv = local_valid;
        end
        chk(32'(total >= 300), 32'h1, "R8 R9 stream forward progress");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        head_valid = '0;
        head_pipe  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(32'(issue_go), 32'h0, "R10 reset issue_go");
        chk(32'(shared_valid), 32'h0, "R10 reset shared_valid");
        @(posedge clk); #1;
        rst_n = 1'b1;
        t_alternate();
        t_half_rate();
        t_fp16();
        t_xu();
        t_rr_rotate();
        t_rr_skip();
        t_parallel();
        t_mixed();
        t_stream();
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule